// File: doc/BRIEF.md
# DAC Settling-Time Step and Strobe Generator

This block sits on chip next to a DAC under test and drives it with a full-scale square pattern. The DAC code swaps between all zeros and all ones once per DAC period, and each swap is a full-scale step. A DAC period is a fixed number of cycles of a fast reference clock. During each period the block raises a one-cycle sampling strobe a programmable number of fast cycles after the update. An external sample-and-hold or integrator and a precision voltmeter use that strobe to capture the DAC output level at that moment.

Stepping the strobe delay across the period traces the settling curve point by point. The delay can be fixed, or a sweep engine can advance it. The sweep holds each delay point for a programmed number of strobes, then adds a programmed step. It raises a done flag once the largest delay has been used. A strobe can be limited to rising steps, to falling steps, or allowed on both. A new delay always waits for the next period boundary, so each strobe uses one whole delay value.

Top module: `settle_step_gen`

## Requirements
- R1: While reset is asserted and after it is released with `enable` low, `dac_code` is all zeros and `dac_upd`, `strobe` and `sweep_done` are low.
- R2: While `enable` is high, `dac_code` changes only at a period start, and it alternates between all zeros and all ones. The first period after `enable` rises carries all ones (a rising step). With `enable` low, `dac_code` returns to all zeros and no updates occur.
- R3: `dac_upd` is high for exactly one fast cycle, the first cycle of each DAC period. Consecutive updates are `PERIOD_CYC` fast cycles apart.
- R4: In a period where a strobe is allowed, `strobe` is high for exactly one fast cycle, D fast cycles after the `dac_upd` cycle (in the same cycle when D = 0). `strobe_dly` shows D.
- R5: A requested delay above `PERIOD_CYC-1` is clamped to `PERIOD_CYC-1`.
- R6: The edge selection `cfg_edge` is encoded as follows: 2'b01 allows a strobe only in periods that carry all ones (rising step), 2'b10 only in periods that carry all zeros (falling step), and 2'b00 or 2'b11 in every period.
- R7: A change of `cfg_delay` takes effect only at the next period start. A strobe already pending in the current period keeps the old delay.
- R8: With `cfg_sweep` high, the first delay point is the clamped `cfg_delay`. Each point is used for max(`cfg_repeat`,1) strobes. The next point is the current one plus max(`cfg_step`,1), clamped to `PERIOD_CYC-1`, and it applies from the next period start.
- R9: After the last strobe of the point at `PERIOD_CYC-1`, `sweep_done` goes high and stays high, and no further strobe occurs. `sweep_done` clears once `enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the pattern; low idles the block and clears the sweep |
| cfg_delay | input | DIN_W | Requested strobe delay in fast cycles (sweep start point in sweep mode) |
| cfg_edge | input | 2 | Edge selection for strobes |
| cfg_sweep | input | 1 | Selects sweep mode |
| cfg_step | input | DIN_W | Sweep increment (0 acts as 1) |
| cfg_repeat | input | REP_W | Strobes per sweep point (0 acts as 1) |
| dac_code | output | CODE_W | Code driven into the DAC under test |
| dac_upd | output | 1 | Marks the first fast cycle of each DAC period |
| strobe | output | 1 | Sampling strobe for the external sample-and-hold |
| strobe_dly | output | $clog2(PERIOD_CYC) | Delay in force for the current period |
| sweep_done | output | 1 | Sweep finished |

## Verification
Fixed delays are applied at zero, mid-period, the last cycle of the period and far above the period. These separate correct strobe placement from off-by-one errors and from missing clamping. Each edge selection value is run over several periods, which shows whether strobes fall only on the chosen step polarity. A delay changed inside a period shows whether the pending strobe keeps its old delay. Directed and random sweeps, including zero step and zero repeat values, are checked against a bench-computed list of delay points. This shows whether the repeat counting, the step clamping at the top point, the strobe count before `sweep_done` and the silence after it are all correct.

// File: rtl/settle_pkg.sv
package settle_pkg;
  typedef enum logic [1:0] {
    EDGE_ANY0 = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/settle_period_timer.sv
module settle_period_timer #(
  parameter int PERIOD_CYC = 16,
  parameter int CODE_W     = 10,
  localparam int PH_W      = $clog2(PERIOD_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  output logic              run,
  output logic              start,
  output logic              first,
  output logic              upd,
  output logic [PH_W-1:0]   phase,
  output logic [CODE_W-1:0] code
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PERIOD_CYC - 1);

  logic [PH_W-1:0]   phase_n;
  logic [CODE_W-1:0] code_n;
  logic              run_n;

  assign first = enable && !run;
  assign start = enable && (!run || (phase == LAST_PH));
  assign upd   = run && (phase == '0);

  always_comb begin
    phase_n = phase;
    code_n  = code;
    run_n   = enable;
    if (!enable) begin
      phase_n = '0;
      code_n  = '0;
    end else if (start) begin
      phase_n = '0;
      code_n  = ~code;
    end else begin
      phase_n = phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      code  <= '0;
      run   <= 1'b0;
    end else begin
      phase <= phase_n;
      code  <= code_n;
      run   <= run_n;
    end
  end

  AST_UPD_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> (code == ~$past(code))) else $error("upd without toggle"); // R2
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !upd) |-> $stable(code)) else $error("code moved mid period"); // R2
endmodule

// File: rtl/settle_delay_sched.sv
module settle_delay_sched #(
  parameter int PERIOD_CYC = 16,
  parameter int DIN_W      = 8,
  parameter int REP_W      = 4,
  localparam int DLY_W     = $clog2(PERIOD_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic             first,
  input  logic             fire,
  input  logic [DIN_W-1:0] cfg_delay,
  input  logic             cfg_sweep,
  input  logic [DIN_W-1:0] cfg_step,
  input  logic [REP_W-1:0] cfg_repeat,
  output logic [DLY_W-1:0] act_dly,
  output logic             done
);
  localparam logic [DIN_W-1:0] MAX_IN  = DIN_W'(PERIOD_CYC - 1);
  localparam logic [DLY_W-1:0] MAX_DLY = DLY_W'(PERIOD_CYC - 1);

  logic [DLY_W-1:0] swp, swp_n, act_n, req, swp_adv;
  logic [REP_W-1:0] cnt, cnt_n, rep_eff;
  logic [REP_W:0]   cnt_inc;
  logic [DIN_W-1:0] step_eff;
  logic [DIN_W:0]   sum;
  logic             done_n, last_rep;

  assign req      = (cfg_delay > MAX_IN) ? MAX_DLY : cfg_delay[DLY_W-1:0];
  assign step_eff = (cfg_step == '0) ? DIN_W'(1) : cfg_step;
  assign rep_eff  = (cfg_repeat == '0) ? REP_W'(1) : cfg_repeat;
  assign sum      = {{(DIN_W + 1 - DLY_W){1'b0}}, swp} + {1'b0, step_eff};
  assign swp_adv  = (sum > {1'b0, MAX_IN}) ? MAX_DLY : sum[DLY_W-1:0];
  assign cnt_inc  = {1'b0, cnt} + 1'b1;
  assign last_rep = cnt_inc >= {1'b0, rep_eff};

  always_comb begin
    act_n  = act_dly;
    swp_n  = swp;
    cnt_n  = cnt;
    done_n = done;
    if (!enable) begin
      cnt_n  = '0;
      done_n = 1'b0;
    end else begin
      if (fire && cfg_sweep && !done) begin
        if (last_rep) begin
          cnt_n = '0;
          if (swp == MAX_DLY) done_n = 1'b1;
          else                swp_n  = swp_adv;
        end else begin
          cnt_n = cnt_inc[REP_W-1:0];
        end
      end
      if (first) begin
        swp_n  = req;
        cnt_n  = '0;
        done_n = 1'b0;
      end
      if (start) act_n = cfg_sweep ? swp_n : req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_dly <= '0;
      swp     <= '0;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      act_dly <= act_n;
      swp     <= swp_n;
      cnt     <= cnt_n;
      done    <= done_n;
    end
  end

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !done) else $error("done survived disable"); // R9
endmodule

// File: rtl/settle_step_gen.sv
module settle_step_gen #(
  parameter int PERIOD_CYC = 16,
  parameter int DIN_W      = 8,
  parameter int REP_W      = 4,
  parameter int CODE_W     = 10,
  localparam int DLY_W     = $clog2(PERIOD_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIN_W-1:0]  cfg_delay,
  input  logic [1:0]        cfg_edge,
  input  logic              cfg_sweep,
  input  logic [DIN_W-1:0]  cfg_step,
  input  logic [REP_W-1:0]  cfg_repeat,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_upd,
  output logic              strobe,
  output logic [DLY_W-1:0]  strobe_dly,
  output logic              sweep_done
);
  import settle_pkg::*;

  logic       rst_q1, rst_q2;
  logic       run, start, first;
  logic [DLY_W-1:0] phase;
  logic       edge_ok;
  edge_sel_e  edge_mode;

  // reset asserts at once and releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  settle_period_timer #(.PERIOD_CYC(PERIOD_CYC), .CODE_W(CODE_W)) u_timer (
    .clk(clk), .rst_n(rst_q2), .enable(enable), .run(run), .start(start),
    .first(first), .upd(dac_upd), .phase(phase), .code(dac_code)
  );

  settle_delay_sched #(.PERIOD_CYC(PERIOD_CYC), .DIN_W(DIN_W), .REP_W(REP_W)) u_sched (
    .clk(clk), .rst_n(rst_q2), .enable(enable), .start(start), .first(first),
    .fire(strobe), .cfg_delay(cfg_delay), .cfg_sweep(cfg_sweep),
    .cfg_step(cfg_step), .cfg_repeat(cfg_repeat), .act_dly(strobe_dly),
    .done(sweep_done)
  );

  assign edge_mode = edge_sel_e'(cfg_edge);

  always_comb begin
    case (edge_mode)
      EDGE_RISE: edge_ok = &dac_code;
      EDGE_FALL: edge_ok = ~|dac_code;
      default:   edge_ok = 1'b1;
    endcase
  end

  assign strobe = run && (phase == strobe_dly) && edge_ok && !sweep_done;

  AST_DLY_HOLD: assert property (@(posedge clk) disable iff (!rst_q2)
    (run && !dac_upd) |-> $stable(strobe_dly)) else $error("delay moved mid period"); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_q2)
    strobe |=> !strobe) else $error("strobe longer than one cycle"); // R4
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_q2)
    sweep_done |-> !strobe) else $error("strobe after done"); // R9
  AST_EDGE_RISE: assert property (@(posedge clk) disable iff (!rst_q2)
    (strobe && cfg_edge == 2'b01) |-> (&dac_code)) else $error("strobe on falling step"); // R6
  AST_EDGE_FALL: assert property (@(posedge clk) disable iff (!rst_q2)
    (strobe && cfg_edge == 2'b10) |-> (~|dac_code)) else $error("strobe on rising step"); // R6
endmodule

// File: tb/test_settle_step_gen.sv
module test_settle_step_gen;
  localparam int PER = 16, DIN_W = 8, REP_W = 4, CODE_W = 10, DLY_W = 4;
  localparam int MAXD = PER - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, enable, cfg_sweep;
  logic [DIN_W-1:0] cfg_delay, cfg_step;
  logic [1:0] cfg_edge;
  logic [REP_W-1:0] cfg_repeat;
  logic [CODE_W-1:0] dac_code;
  logic dac_upd, strobe, sweep_done;
  logic [DLY_W-1:0] strobe_dly;

  settle_step_gen #(.PERIOD_CYC(PER), .DIN_W(DIN_W), .REP_W(REP_W), .CODE_W(CODE_W)) i_settle_step_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_delay(cfg_delay),
    .cfg_edge(cfg_edge), .cfg_sweep(cfg_sweep), .cfg_step(cfg_step),
    .cfg_repeat(cfg_repeat), .dac_code(dac_code), .dac_upd(dac_upd),
    .strobe(strobe), .strobe_dly(strobe_dly), .sweep_done(sweep_done)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clampd(input int d);
    return (d > MAXD) ? MAXD : d;
  endfunction

  function automatic bit allowed(input int mode, input bit ones);
    if (mode == 1) return ones;
    if (mode == 2) return !ones;
    return 1'b1;
  endfunction

  function automatic int sweep_pt(input int st, input int sp, input int rp, input int k);
    int s = clampd(st);
    int r = (rp == 0) ? 1 : rp;
    int d = (sp == 0) ? 1 : sp;
    for (int j = 0; j < k / r; j++) s = (s + d > MAXD) ? MAXD : s + d;
    return s;
  endfunction

  function automatic int sweep_total(input int st, input int sp, input int rp);
    int s = clampd(st);
    int r = (rp == 0) ? 1 : rp;
    int d = (sp == 0) ? 1 : sp;
    int n = 1;
    while (s != MAXD) begin
      s = (s + d > MAXD) ? MAXD : s + d;
      n++;
    end
    return n * r;
  endfunction

  // monitor state
  int snap_dly = 0;
  bit have_upd = 0, seen = 0, qual = 0, done_start = 0;
  int gap = 0, since = 0, exp_dly = 0, stb_k = 0, last_stb_since = -1;
  logic [CODE_W-1:0] prev_code;

  always @(posedge clk) snap_dly = int'(cfg_delay);

  always @(negedge clk) begin
    if (rst_n && enable) begin
      gap++;
      since++;
      if (dac_upd) begin
        if (have_upd) begin
          chk(gap == PER, "R3 period", gap, PER);
          chk(seen == (qual && !done_start), "R4 R6 strobe presence", seen, qual && !done_start);
          chk(dac_code == ~prev_code, "R2 alternation", dac_code, ~prev_code);
        end else begin
          chk(dac_code == '1, "R2 first rising", dac_code, (1 << CODE_W) - 1);
        end
        gap = 0; since = 0; have_upd = 1; prev_code = dac_code; seen = 0;
        qual = allowed(cfg_edge, &dac_code);
        done_start = sweep_done;
        exp_dly = cfg_sweep ? sweep_pt(snap_dly, cfg_step, cfg_repeat, stb_k) : clampd(snap_dly);
      end
      if (strobe) begin
        chk(have_upd, "R4 strobe before update", 0, 1);
        chk(since == exp_dly, "R4 R5 R7 R8 strobe delay", since, exp_dly);
        chk(strobe_dly == since, "R4 strobe_dly", strobe_dly, since);
        chk(qual, "R6 edge", &dac_code, cfg_edge);
        chk(!seen, "R4 single strobe", 1, 0);
        chk(!done_start, "R9 strobe after done", 1, 0);
        seen = 1; stb_k++; last_stb_since = since;
      end
    end else begin
      have_upd = 0; stb_k = 0; seen = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_run();
    @(negedge clk); #1 enable = 1'b0;
    idle(2);
    chk(dac_code == '0, "R2 idle code", dac_code, 0);
    chk(!dac_upd && !strobe, "R2 idle quiet", dac_upd, 0);
  endtask

  task automatic run_fixed(input int d, input int mode, input int periods);
    @(negedge clk); #1;
    cfg_delay = DIN_W'(d); cfg_edge = 2'(mode); cfg_sweep = 1'b0; enable = 1'b1;
    idle(periods * PER + 2);
    stop_run();
  endtask

  task automatic run_sweep(input int st, input int sp, input int rp, input int mode);
    int tot = sweep_total(st, sp, rp);
    int k;
    @(negedge clk); #1;
    cfg_delay = DIN_W'(st); cfg_step = DIN_W'(sp); cfg_repeat = REP_W'(rp);
    cfg_edge = 2'(mode); cfg_sweep = 1'b1; enable = 1'b1;
    for (int i = 0; i < 8000 && !sweep_done; i++) @(negedge clk);
    chk(sweep_done, "R9 done raised", sweep_done, 1);
    chk(stb_k == tot, "R8 R9 strobe count", stb_k, tot);
    k = stb_k;
    idle(3 * PER);
    chk(sweep_done, "R9 done held", sweep_done, 1);
    chk(stb_k == k, "R9 silent after done", stb_k, k);
    @(negedge clk); #1 enable = 1'b0;
    idle(2);
    chk(!sweep_done, "R9 done cleared", sweep_done, 0);
    cfg_sweep = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; enable = 1'b0; cfg_delay = '0; cfg_edge = 2'b00;
    cfg_sweep = 1'b0; cfg_step = '0; cfg_repeat = '0;
    idle(3);
    chk(dac_code == '0 && !dac_upd && !strobe && !sweep_done, "R1 in reset", dac_code, 0);
    #1 rst_n = 1'b1;
    cfg_delay = 8'd7; cfg_edge = 2'b11;
    idle(6);
    chk(dac_code == '0, "R1 code after reset", dac_code, 0);
    chk(!dac_upd && !strobe && !sweep_done, "R1 outputs after reset", strobe, 0);

    // directed fixed delays, including clamp
    run_fixed(5, 0, 6);
    run_fixed(0, 3, 4);     // R4 strobe with update
    run_fixed(MAXD, 3, 4);  // R5 top value
    run_fixed(200, 0, 4);   // R5 clamped
    run_fixed(6, 1, 6);     // R6 rising only
    run_fixed(9, 2, 6);     // R6 falling only

    // R7 mid-period change
    @(negedge clk); #1;
    cfg_delay = 8'd9; cfg_edge = 2'b11; enable = 1'b1;
    do @(negedge clk); while (!dac_upd);
    idle(2); #1 cfg_delay = 8'd4;
    idle(8);
    chk(last_stb_since == 9, "R7 old delay kept", last_stb_since, 9);
    do @(negedge clk); while (!dac_upd);
    idle(5);
    chk(last_stb_since == 4, "R7 new delay at period start", last_stb_since, 4);
    stop_run();

    // random fixed runs
    for (int i = 0; i < 16; i++)
      run_fixed($urandom_range(0, 40), $urandom_range(0, 3), $urandom_range(3, 5));

    // sweeps
    run_sweep(2, 4, 2, 3);
    run_sweep(0, 0, 0, 0);
    run_sweep(30, 3, 1, 3);
    for (int i = 0; i < 3; i++)
      run_sweep($urandom_range(0, 20), $urandom_range(0, 6), $urandom_range(0, 3), $urandom_range(0, 3));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule